// File: doc/BRIEF.md
# Exception Entry State Updater

This unit performs the architectural register update that a processor core needs when it takes a synchronous exception. The core presents one request at a time. Each request carries a cause code, the address of the faulting instruction, a fault effective address, a store/load flag, a reason code for storage and program faults, and the current machine state word. The unit then builds the new machine state word and the two save/restore words. For data-side faults it also loads the fault address and fault status registers. It then produces the redirected fetch address.

All registers are 64 bits wide. Bit positions in this brief use MSB-0 numbering, so bit k is vector index 63-k. The unit checks the recoverable bit of the incoming machine state. When that bit is clear the exception nests inside another one, and the unit reports a double fault, but the update still completes. A cause or reason code the unit does not know leaves all state untouched and raises an internal-error pulse instead.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is held and after it is released, taken, double fault, internal error, the next address and all five state outputs read zero, and ready reads one.
- R2: On a taken exception, the new machine state equals the incoming word with bits 45, 48, 49, 50, 52, 53, 54, 55, 58, 59 and 62 cleared and bit 0 (64-bit mode) set. Bit 62 is the recoverable bit. No other bit changes.
- R3: The saved state word is the incoming machine state masked to bits 0–32, 37–41 and 48–63, ORed with the cause-specific reason bits of R9 and R10. Every other cause adds no bits.
- R4: The saved address receives the instruction address. For a system call (cause 6) it receives that address plus 4.
- R5: The cause codes map to vector offsets as follows: 0 machine check 0x200, 1 data storage 0x300, 2 instruction storage 0x400, 3 alignment 0x600, 4 program 0x700, 5 FP unavailable 0x800, 6 system call 0xC00, 7 FP assist 0xE00. Causes other than 1 and 3 leave the fault address and fault status outputs unchanged.
- R6: The next address is the vector offset plus a base. The base is all ones in bits 0–43 when bit 57 (interrupt prefix) of the new machine state is set, and zero otherwise.
- R7: When bit 62 of the incoming machine state is clear, a double-fault pulse accompanies the taken pulse. All state updates happen as usual.
- R8: A data storage fault (cause 1) loads the fault address with the effective address. It loads the fault status with one reason bit, ORed with bit 38 for a store. The reasons are: 0 direct-store error bit 32, 1 hash/translation miss bit 33, 2 protection bit 36, 3 external-access violation bit 43, 4 segment-table miss bit 42, 5 external-access disabled bit 44.
- R9: An instruction storage fault (cause 2) ORs one bit into the saved state word: reason 0 bit 35, reason 1 bit 33, reason 2 bit 36, reason 4 bit 42. Fault address and status stay unchanged.
- R10: A program exception (cause 4) ORs exactly one bit into the saved state word: reason 0 FP-enabled bit 43, reason 1 illegal bit 44, reason 4 unsupported optional instruction bit 44, reason 2 privileged bit 45, reason 3 trap bit 46.
- R11: An alignment exception (cause 3) loads the fault address with the effective address and clears the fault status.
- R12: Causes 8–15 raise the internal-error pulse. So do reasons 6–7 on cause 1, reasons 3 and 5–7 on cause 2, and reasons 5–7 on cause 4. In each case no taken pulse is given and every state output and the next address stay unchanged.
- R13: A request is accepted when valid and ready are both high. Results appear on the next clock edge with a one-cycle taken pulse. Ready is low in that cycle and returns high in the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Exception request present |
| req_ready_o | output | 1 | Unit can accept a request |
| cause_i | input | 4 | Exception cause code |
| reason_i | input | 3 | Storage or program reason code |
| is_store_i | input | 1 | Faulting data access was a store |
| cia_i | input | 64 | Address of the current instruction |
| ea_i | input | 64 | Faulting effective address |
| msr_i | input | 64 | Current machine state word |
| taken_o | output | 1 | One-cycle pulse: exception taken, outputs valid |
| next_pc_o | output | 64 | Redirected fetch address |
| double_fault_o | output | 1 | Pulse: exception taken while recoverable bit clear |
| int_err_o | output | 1 | Pulse: unknown cause or reason, nothing updated |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved machine state word |
| msr_o | output | 64 | New machine state word |
| dar_o | output | 64 | Fault address register |
| dsisr_o | output | 64 | Fault status register |

## Verification
Every cause is driven at least once. The incoming machine state words have the interrupt prefix both set and clear, so the vector offset table and the base selection are checked separately. The state words are dense, so a wrong clear or keep mask shows up in the new state or the saved state. Every storage and program reason is swept, and both store and load forms of data faults are used, so each reason bit and the store bit are checked in their own positions. Unknown codes follow valid requests that left non-zero fault registers, so a change to held state is visible. A request with the recoverable bit clear shows that the double-fault flag appears alongside a complete update.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN        = 64;
    localparam int CAUSE_W     = 4;
    localparam int REASON_W    = 3;
    localparam int VEC_W       = 12;
    localparam int PREFIX_ONES = 44;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [CAUSE_W-1:0] {
        CS_MCHK  = 4'd0,
        CS_DSTOR = 4'd1,
        CS_ISTOR = 4'd2,
        CS_ALIGN = 4'd3,
        CS_PROG  = 4'd4,
        CS_FPUN  = 4'd5,
        CS_SCALL = 4'd6,
        CS_FPAS  = 4'd7
    } cause_e;

    typedef enum logic [REASON_W-1:0] {
        SR_DIRECT  = 3'd0,
        SR_HASH    = 3'd1,
        SR_PROT    = 3'd2,
        SR_XVIOL   = 3'd3,
        SR_SEGMISS = 3'd4,
        SR_XDIS    = 3'd5
    } stor_reason_e;

    typedef enum logic [REASON_W-1:0] {
        PR_FPEN  = 3'd0,
        PR_ILL   = 3'd1,
        PR_PRIV  = 3'd2,
        PR_TRAP  = 3'd3,
        PR_OPTNL = 3'd4
    } prog_reason_e;

    // machine state bit positions, MSB-0
    localparam int MB_SF  = 0;
    localparam int MB_POW = 45;
    localparam int MB_EE  = 48;
    localparam int MB_PR  = 49;
    localparam int MB_FP  = 50;
    localparam int MB_FE0 = 52;
    localparam int MB_SE  = 53;
    localparam int MB_BE  = 54;
    localparam int MB_FE1 = 55;
    localparam int MB_IP  = 57;
    localparam int MB_IR  = 58;
    localparam int MB_DR  = 59;
    localparam int MB_RI  = 62;

    // fault status bit positions, MSB-0
    localparam int FS_DIRECT  = 32;
    localparam int FS_HASH    = 33;
    localparam int FS_PROT    = 36;
    localparam int FS_STORE   = 38;
    localparam int FS_SEGMISS = 42;
    localparam int FS_XVIOL   = 43;
    localparam int FS_XDIS    = 44;

    // saved-state reason bit positions, MSB-0
    localparam int SV_HASH    = 33;
    localparam int SV_DIRECT  = 35;
    localparam int SV_PROT    = 36;
    localparam int SV_SEGMISS = 42;
    localparam int SV_FPEN    = 43;
    localparam int SV_ILL     = 44;
    localparam int SV_PRIV    = 45;
    localparam int SV_TRAP    = 46;

    function automatic word_t mbit(input int k);
        word_t w;
        w = '0;
        w[XLEN-1-k] = 1'b1;
        return w;
    endfunction

    function automatic word_t mrange(input int lo, input int hi);
        word_t w;
        w = '0;
        for (int k = lo; k <= hi; k++) w[XLEN-1-k] = 1'b1;
        return w;
    endfunction

    localparam word_t MSR_ENTRY_CLR = mbit(MB_POW) | mbit(MB_EE) | mbit(MB_PR)
                                    | mbit(MB_FP)  | mbit(MB_FE0) | mbit(MB_SE)
                                    | mbit(MB_BE)  | mbit(MB_FE1) | mbit(MB_IR)
                                    | mbit(MB_DR)  | mbit(MB_RI);
    localparam word_t MSR_ENTRY_SET = mbit(MB_SF);
    localparam word_t SRR1_KEEP     = mrange(0, 32) | mrange(37, 41) | mrange(48, 63);
    localparam word_t PREFIX_BASE   = mrange(0, PREFIX_ONES-1);

    typedef struct packed {
        logic             ok;
        logic [VEC_W-1:0] vec;
        word_t            srr1_set;
        logic             dar_we;
        logic             dsisr_we;
        word_t            dsisr_val;
        logic             pc_plus4;
    } exc_dec_t;

    function automatic logic [VEC_W-1:0] vec_of(input cause_e c);
        case (c)
            CS_MCHK:  return VEC_W'(12'h200);
            CS_DSTOR: return VEC_W'(12'h300);
            CS_ISTOR: return VEC_W'(12'h400);
            CS_ALIGN: return VEC_W'(12'h600);
            CS_PROG:  return VEC_W'(12'h700);
            CS_FPUN:  return VEC_W'(12'h800);
            CS_SCALL: return VEC_W'(12'hC00);
            CS_FPAS:  return VEC_W'(12'hE00);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [REASON_W-1:0] reason_i,
    input  logic                is_store_i,
    output exc_dec_t            dec_o
);

    cause_e       cause;
    stor_reason_e sreason;
    prog_reason_e preason;
    word_t        store_bit;

    assign cause     = cause_e'(cause_i);
    assign sreason   = stor_reason_e'(reason_i);
    assign preason   = prog_reason_e'(reason_i);
    assign store_bit = is_store_i ? mbit(FS_STORE) : '0;

    always_comb begin
        dec_o           = '0;
        dec_o.ok        = 1'b1;
        dec_o.vec       = vec_of(cause);
        case (cause)
            CS_MCHK, CS_FPUN, CS_FPAS: ;
            CS_SCALL: dec_o.pc_plus4 = 1'b1;
            CS_DSTOR: begin
                dec_o.dar_we   = 1'b1;
                dec_o.dsisr_we = 1'b1;
                case (sreason)
                    SR_DIRECT:  dec_o.dsisr_val = mbit(FS_DIRECT)  | store_bit;
                    SR_HASH:    dec_o.dsisr_val = mbit(FS_HASH)    | store_bit;
                    SR_PROT:    dec_o.dsisr_val = mbit(FS_PROT)    | store_bit;
                    SR_XVIOL:   dec_o.dsisr_val = mbit(FS_XVIOL)   | store_bit;
                    SR_SEGMISS: dec_o.dsisr_val = mbit(FS_SEGMISS) | store_bit;
                    SR_XDIS:    dec_o.dsisr_val = mbit(FS_XDIS)    | store_bit;
                    default:    dec_o.ok = 1'b0;
                endcase
            end
            CS_ISTOR: begin
                case (sreason)
                    SR_DIRECT:  dec_o.srr1_set = mbit(SV_DIRECT);
                    SR_HASH:    dec_o.srr1_set = mbit(SV_HASH);
                    SR_PROT:    dec_o.srr1_set = mbit(SV_PROT);
                    SR_SEGMISS: dec_o.srr1_set = mbit(SV_SEGMISS);
                    default:    dec_o.ok = 1'b0;
                endcase
            end
            CS_ALIGN: begin
                dec_o.dar_we    = 1'b1;
                dec_o.dsisr_we  = 1'b1;
                dec_o.dsisr_val = '0;
            end
            CS_PROG: begin
                case (preason)
                    PR_FPEN:         dec_o.srr1_set = mbit(SV_FPEN);
                    PR_ILL, PR_OPTNL: dec_o.srr1_set = mbit(SV_ILL);
                    PR_PRIV:         dec_o.srr1_set = mbit(SV_PRIV);
                    PR_TRAP:         dec_o.srr1_set = mbit(SV_TRAP);
                    default:         dec_o.ok = 1'b0;
                endcase
            end
            default: dec_o.ok = 1'b0;
        endcase
        if (!dec_o.ok) begin
            dec_o.dar_we   = 1'b0;
            dec_o.dsisr_we = 1'b0;
        end
    end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
    import exc_entry_pkg::*;
#(
    parameter int PC_STEP = 4
) (
    input  word_t    msr_old_i,
    input  word_t    cia_i,
    input  exc_dec_t dec_i,
    output word_t    msr_new_o,
    output word_t    srr0_new_o,
    output word_t    srr1_new_o,
    output word_t    target_o
);

    localparam int PAD_W = XLEN - VEC_W;

    word_t base;

    assign msr_new_o  = (msr_old_i & ~MSR_ENTRY_CLR) | MSR_ENTRY_SET;
    assign srr1_new_o = (msr_old_i & SRR1_KEEP) | dec_i.srr1_set;
    assign srr0_new_o = dec_i.pc_plus4 ? (cia_i + XLEN'(PC_STEP)) : cia_i;
    assign base       = msr_new_o[XLEN-1-MB_IP] ? PREFIX_BASE : '0;
    assign target_o   = base + {{PAD_W{1'b0}}, dec_i.vec};

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int PC_STEP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [REASON_W-1:0] reason_i,
    input  logic                is_store_i,
    input  logic [XLEN-1:0]     cia_i,
    input  logic [XLEN-1:0]     ea_i,
    input  logic [XLEN-1:0]     msr_i,
    output logic                taken_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                double_fault_o,
    output logic                int_err_o,
    output logic [XLEN-1:0]     srr0_o,
    output logic [XLEN-1:0]     srr1_o,
    output logic [XLEN-1:0]     msr_o,
    output logic [XLEN-1:0]     dar_o,
    output logic [XLEN-1:0]     dsisr_o
);

    exc_dec_t dec;
    word_t    msr_new, srr0_new, srr1_new, target;
    logic     busy_q;
    logic     accept, commit;

    exc_cause_decode u_decode (
        .cause_i    (cause_i),
        .reason_i   (reason_i),
        .is_store_i (is_store_i),
        .dec_o      (dec)
    );

    exc_state_calc #(.PC_STEP(PC_STEP)) u_calc (
        .msr_old_i  (msr_i),
        .cia_i      (cia_i),
        .dec_i      (dec),
        .msr_new_o  (msr_new),
        .srr0_new_o (srr0_new),
        .srr1_new_o (srr1_new),
        .target_o   (target)
    );

    assign req_ready_o = ~busy_q;
    assign accept      = req_valid_i & req_ready_o;
    assign commit      = accept & dec.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q         <= 1'b0;
            taken_o        <= 1'b0;
            double_fault_o <= 1'b0;
            int_err_o      <= 1'b0;
        end else begin
            busy_q         <= accept;
            taken_o        <= commit;
            double_fault_o <= commit & ~msr_i[XLEN-1-MB_RI];
            int_err_o      <= accept & ~dec.ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o <= '0;
            srr0_o    <= '0;
            srr1_o    <= '0;
            msr_o     <= '0;
        end else if (commit) begin
            next_pc_o <= target;
            srr0_o    <= srr0_new;
            srr1_o    <= srr1_new;
            msr_o     <= msr_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dar_o   <= '0;
            dsisr_o <= '0;
        end else if (commit) begin
            if (dec.dar_we)   dar_o   <= ea_i;
            if (dec.dsisr_we) dsisr_o <= dec.dsisr_val;
        end
    end

endmodule

// File: rtl/exc_entry_sva.sv
module exc_entry_sva
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid_i,
    input logic            req_ready_o,
    input logic            taken_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            double_fault_o,
    input logic            int_err_o,
    input logic [XLEN-1:0] srr0_o,
    input logic [XLEN-1:0] srr1_o,
    input logic [XLEN-1:0] msr_o,
    input logic [XLEN-1:0] dar_o,
    input logic [XLEN-1:0] dsisr_o
);

    a_r13_taken_single: assert property (@(posedge clk) disable iff (rst)
        taken_o |=> !taken_o);

    a_r13_ready_low: assert property (@(posedge clk) disable iff (rst)
        (taken_o || int_err_o) |-> !req_ready_o);

    a_r13_accept_answers: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> (taken_o || int_err_o));

    a_r7_dfault_with_taken: assert property (@(posedge clk) disable iff (rst)
        double_fault_o |-> taken_o);

    a_r2_msr_entry_bits: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (msr_o[XLEN-1-MB_SF] && !msr_o[XLEN-1-MB_RI] && !msr_o[XLEN-1-MB_EE]));

    a_r6_vector_granule: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (next_pc_o[7:0] == 8'h00));

    a_r12_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(int_err_o && taken_o));

    a_r12_err_holds: assert property (@(posedge clk) disable iff (rst)
        int_err_o |-> ($stable(srr0_o) && $stable(srr1_o) && $stable(msr_o)
                       && $stable(dar_o) && $stable(dsisr_o) && $stable(next_pc_o)));

endmodule

bind exc_entry_unit exc_entry_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .taken_o        (taken_o),
    .next_pc_o      (next_pc_o),
    .double_fault_o (double_fault_o),
    .int_err_o      (int_err_o),
    .srr0_o         (srr0_o),
    .srr1_o         (srr1_o),
    .msr_o          (msr_o),
    .dar_o          (dar_o),
    .dsisr_o        (dsisr_o)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i;
    logic        req_ready_o;
    logic [3:0]  cause_i;
    logic [2:0]  reason_i;
    logic        is_store_i;
    logic [63:0] cia_i, ea_i, msr_i;
    logic        taken_o, double_fault_o, int_err_o;
    logic [63:0] next_pc_o, srr0_o, srr1_o, msr_o, dar_o, dsisr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // snapshot taken at the negedge after acceptance
    logic        s_ready, s_taken, s_dfault, s_err;
    logic [63:0] s_pc, s_srr0, s_srr1, s_msr, s_dar, s_dsisr;

    always #2 clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .cause_i(cause_i), .reason_i(reason_i), .is_store_i(is_store_i),
        .cia_i(cia_i), .ea_i(ea_i), .msr_i(msr_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .double_fault_o(double_fault_o),
        .int_err_o(int_err_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o),
        .dar_o(dar_o), .dsisr_o(dsisr_o)
    );

    function automatic logic [63:0] b(input int k);
        return 64'h1 << (63 - k);
    endfunction

    function automatic logic [63:0] exp_msr(input logic [63:0] old);
        logic [63:0] clr;
        clr = b(45) | b(48) | b(49) | b(50) | b(52) | b(53) | b(54) | b(55)
            | b(58) | b(59) | b(62);
        return (old & ~clr) | b(0);
    endfunction

    function automatic logic [63:0] exp_srr1(input logic [63:0] old, input logic [63:0] add);
        return (old & 64'hFFFF_FFFF_87C0_FFFF) | add;
    endfunction

    function automatic logic [63:0] exp_pc(input logic [63:0] newmsr, input logic [63:0] off);
        return (newmsr[63-57] ? 64'hFFFF_FFFF_FFF0_0000 : 64'h0) + off;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [2:0] r, input logic st,
                       input logic [63:0] cia, input logic [63:0] ea, input logic [63:0] msr);
        @(negedge clk);
        req_valid_i = 1'b1; cause_i = c; reason_i = r; is_store_i = st;
        cia_i = cia; ea_i = ea; msr_i = msr;
        @(negedge clk);
        s_ready = req_ready_o; s_taken = taken_o; s_dfault = double_fault_o; s_err = int_err_o;
        s_pc = next_pc_o; s_srr0 = srr0_o; s_srr1 = srr1_o; s_msr = msr_o;
        s_dar = dar_o; s_dsisr = dsisr_o;
        req_valid_i = 1'b0;
        @(negedge clk);
    endtask

    // common checks for a taken exception
    task automatic chk_taken(input string req, input logic [63:0] msr, input logic [63:0] cia,
                             input logic [63:0] off, input logic [63:0] add, input logic dfe);
        chk("R13", "taken", {63'b0, s_taken}, 64'd1);
        chk("R13", "ready low", {63'b0, s_ready}, 64'd0);
        chk("R12", "no error", {63'b0, s_err}, 64'd0);
        chk("R2", {req, " msr"}, s_msr, exp_msr(msr));
        chk("R3", {req, " srr1"}, s_srr1, exp_srr1(msr, add));
        chk("R4", {req, " srr0"}, s_srr0, cia);
        chk("R6", {req, " next pc"}, s_pc, exp_pc(exp_msr(msr), off));
        chk("R7", {req, " double fault"}, {63'b0, s_dfault}, {63'b0, dfe});
    endtask

    localparam logic [63:0] MSR_A = 64'h1234_5678_9ABC_DEF2; // RI set, prefix set
    localparam logic [63:0] MSR_B = 64'hFEDC_BA98_7654_FFB6; // RI set, prefix clear

    task automatic t_reset();
        chk("R1", "ready", {63'b0, req_ready_o}, 64'd1);
        chk("R1", "taken", {63'b0, taken_o}, 64'd0);
        chk("R1", "flags", {62'b0, double_fault_o, int_err_o}, 64'd0);
        chk("R1", "next pc", next_pc_o, 64'd0);
        chk("R1", "state", srr0_o | srr1_o | msr_o | dar_o | dsisr_o, 64'd0);
    endtask

    task automatic t_mchk();
        run(4'd0, 3'd0, 1'b0, 64'h0000_0000_0010_0040, 64'hDEAD, MSR_B);
        chk_taken("R5", MSR_B, 64'h0000_0000_0010_0040, 64'h200, 64'h0, 1'b0);
        chk("R5", "mchk dar unchanged", s_dar, 64'h0);
        chk("R5", "mchk dsisr unchanged", s_dsisr, 64'h0);
        chk("R13", "taken dropped", {63'b0, taken_o}, 64'd0);
        chk("R13", "ready back", {63'b0, req_ready_o}, 64'd1);
    endtask

    task automatic t_dstor();
        logic [63:0] bits [6];
        bits[0] = b(32); bits[1] = b(33); bits[2] = b(36);
        bits[3] = b(43); bits[4] = b(42); bits[5] = b(44);
        for (int r = 0; r < 6; r++) begin
            for (int st = 0; st < 2; st++) begin
                logic [63:0] ea;
                ea = 64'hA5A5_0000_0000_1000 + 64'(r * 16 + st);
                run(4'd1, 3'(r), st[0], 64'h2000 + 64'(r * 4), ea, (r % 2 == 0) ? MSR_A : MSR_B);
                chk_taken("R8", (r % 2 == 0) ? MSR_A : MSR_B, 64'h2000 + 64'(r * 4),
                          64'h300, 64'h0, 1'b0);
                chk("R8", "dar", s_dar, ea);
                chk("R8", "dsisr", s_dsisr, bits[r] | (st[0] ? b(38) : 64'h0));
            end
        end
    endtask

    task automatic t_istor();
        logic [63:0] pdar, pdsisr, add;
        int rs [4];
        rs[0] = 0; rs[1] = 1; rs[2] = 2; rs[3] = 4;
        for (int i = 0; i < 4; i++) begin
            pdar = dar_o; pdsisr = dsisr_o;
            case (rs[i])
                0: add = b(35);
                1: add = b(33);
                2: add = b(36);
                default: add = b(42);
            endcase
            run(4'd2, 3'(rs[i]), 1'b1, 64'h3000, 64'h1111, MSR_B);
            chk_taken("R9", MSR_B, 64'h3000, 64'h400, add, 1'b0);
            chk("R9", "dar unchanged", s_dar, pdar);
            chk("R9", "dsisr unchanged", s_dsisr, pdsisr);
        end
    endtask

    task automatic t_align();
        run(4'd3, 3'd0, 1'b1, 64'h4004, 64'h0000_7777_0000_0003, MSR_A);
        chk_taken("R11", MSR_A, 64'h4004, 64'h600, 64'h0, 1'b0);
        chk("R11", "dar", s_dar, 64'h0000_7777_0000_0003);
        chk("R11", "dsisr zero", s_dsisr, 64'h0);
    endtask

    task automatic t_prog();
        logic [63:0] add;
        for (int r = 0; r < 5; r++) begin
            case (r)
                0: add = b(43);
                1: add = b(44);
                2: add = b(45);
                3: add = b(46);
                default: add = b(44);
            endcase
            run(4'd4, 3'(r), 1'b0, 64'h5000 + 64'(r * 4), 64'h0, MSR_B);
            chk_taken("R10", MSR_B, 64'h5000 + 64'(r * 4), 64'h700, add, 1'b0);
        end
    endtask

    task automatic t_misc();
        logic [63:0] pdar, pdsisr;
        pdar = dar_o; pdsisr = dsisr_o;
        run(4'd6, 3'd0, 1'b0, 64'h0000_0000_0000_6FFC, 64'h0, MSR_A);
        chk_taken("R4", MSR_A, 64'h0000_0000_0000_7000, 64'hC00, 64'h0, 1'b0);
        run(4'd5, 3'd0, 1'b0, 64'h7000, 64'h0, MSR_B);
        chk_taken("R5", MSR_B, 64'h7000, 64'h800, 64'h0, 1'b0);
        run(4'd7, 3'd0, 1'b0, 64'h8000, 64'h0, MSR_A);
        chk_taken("R5", MSR_A, 64'h8000, 64'hE00, 64'h0, 1'b0);
        chk("R5", "dar unchanged", s_dar, pdar);
        chk("R5", "dsisr unchanged", s_dsisr, pdsisr);
    endtask

    task automatic t_double();
        logic [63:0] m;
        m = MSR_A & ~b(62);
        run(4'd1, 3'd2, 1'b1, 64'h9000, 64'hBEEF_0000, m);
        chk_taken("R7", m, 64'h9000, 64'h300, 64'h0, 1'b1);
        chk("R7", "dar still updated", s_dar, 64'hBEEF_0000);
        chk("R7", "dsisr still updated", s_dsisr, b(36) | b(38));
    endtask

    task automatic t_unknown();
        logic [3:0] cs [8];
        logic [2:0] rs [8];
        cs[0] = 4'd8; rs[0] = 3'd0;  cs[1] = 4'd15; rs[1] = 3'd0;
        cs[2] = 4'd1; rs[2] = 3'd6;  cs[3] = 4'd1;  rs[3] = 3'd7;
        cs[4] = 4'd2; rs[4] = 3'd3;  cs[5] = 4'd2;  rs[5] = 3'd5;
        cs[6] = 4'd4; rs[6] = 3'd5;  cs[7] = 4'd4;  rs[7] = 3'd7;
        for (int i = 0; i < 8; i++) begin
            logic [63:0] p0, p1, pm, pd, ps, pp;
            p0 = srr0_o; p1 = srr1_o; pm = msr_o; pd = dar_o; ps = dsisr_o; pp = next_pc_o;
            run(cs[i], rs[i], 1'b1, 64'hFFFF_0000, 64'h1234_4321, MSR_B & ~b(62));
            chk("R12", "int err", {63'b0, s_err}, 64'd1);
            chk("R12", "no taken", {62'b0, s_taken, s_dfault}, 64'd0);
            chk("R12", "srr0 held", s_srr0, p0);
            chk("R12", "srr1 held", s_srr1, p1);
            chk("R12", "msr held", s_msr, pm);
            chk("R12", "dar held", s_dar, pd);
            chk("R12", "dsisr held", s_dsisr, ps);
            chk("R12", "next pc held", s_pc, pp);
            chk("R12", "err dropped", {63'b0, int_err_o}, 64'd0);
        end
    endtask

    initial begin
        req_valid_i = 1'b0; cause_i = '0; reason_i = '0; is_store_i = 1'b0;
        cia_i = '0; ea_i = '0; msr_i = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mchk();
        t_dstor();
        t_istor();
        t_align();
        t_prog();
        t_misc();
        t_double();
        t_unknown();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
            wait (done);
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule